// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a countdown timer for a processor's local interrupt unit. It is clocked by the bus clock through a programmable power-of-two divider. Software loads an initial count. The counter then steps down by one on every divided tick. On reaching zero it expires: in one-shot mode it stays at zero, and in periodic mode it reloads from the initial count and keeps running. The live count can be read at any time.

Each expiry may raise a one-cycle interrupt request that carries an 8-bit vector taken from the timer's interrupt table entry. The request goes out only when the unit's global software enable is set and the timer entry is not masked. The block also holds the mask bits of the unit's other table entries. This lets the rule "disabling the unit masks every entry" live in one place. Each register has its own write strobe and data bus, so no address decoding is involved.

Top module: `local_irq_timer`

## Requirements
- R1: After reset the current count is 0, the timer entry reads 0x0001_0000 (masked), every entry mask bit is 1, the enable register reads 0 and no interrupt request is raised.
- R2: The divide code is {cfg[3], cfg[1], cfg[0]}, and cfg[2] is ignored. The ratio is 2^((code+1) mod 8), so code 111 divides by 1, 000 by 2 and 110 by 128. With ratio R, the count drops by exactly one every R clock edges. The first drop happens R edges after the load edge.
- R3: Writing the initial count, even while a countdown is running, restarts the countdown from the new value. The count shows the new value after the write edge, and the divider phase restarts at that edge.
- R4: In one-shot mode (entry bit 17 = 0), the count reaches 0 on edge N×R after loading N and stays there, with exactly one interrupt request.
- R5: In periodic mode (entry bit 17 = 1), the edge that would take the count to 0 instead reloads the initial count. An expiry occurs every N×R edges.
- R6: An expiry raises irq_valid for one cycle, in the cycle after the expiry edge, with irq_vector equal to entry bits [7:0]. This happens only if enable register bit 8 is 1 and entry bit 16 (mask) is 0. A masked expiry still counts down but raises no request.
- R7: Writing the enable register with bit 8 = 0 sets the mask bit of every entry. It also drops an expiry that falls on that same edge.
- R8: While the unit is disabled, any entry write stores the mask bit as 1. While the unit is enabled, the mask bit is stored as written.
- R9: The timer entry keeps only bits [7:0], 12, 16 and 17, and all other bits read 0. The enable register keeps only bits [9:0].
- R10: An initial count of 0 stops any countdown, leaves the count at 0 and never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_wr | input | 1 | Initial-count write strobe |
| init_data | input | CNT_W | Initial count value |
| div_wr | input | 1 | Divide-configuration write strobe |
| div_data | input | 4 | Divide configuration (bits 3, 1, 0 used) |
| spur_wr | input | 1 | Enable-register write strobe |
| spur_data | input | 32 | Enable-register data, bit 8 = software enable |
| ent_wr | input | 1 | Table-entry write strobe |
| ent_sel | input | SEL_W | Entry index, 0 = timer entry |
| ent_data | input | 32 | Entry data: [7:0] vector, 12 status, 16 mask, 17 periodic |
| cur_count | output | CNT_W | Current count |
| timer_entry | output | 32 | Stored timer entry |
| entry_masked | output | ENTRIES | Mask bit of every entry |
| spur_q | output | 32 | Stored enable register |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
Every register write becomes visible at the falling edge that follows the write edge. The count after a load of N follows N − floor(k/R) at the k-th edge, and the request appears in the cycle after edge N×R. The bench drives strobes at a falling edge and samples at each following falling edge. It numbers the samples by edges since the load, so each compare lands on the exact cycle that the requirement predicts. For periodic runs it checks the full trace over two periods. The disable-on-expiry case places the enable write on the expiry edge itself.

// File: rtl/lit_pkg.sv
package lit_pkg;
    localparam int VEC_W        = 8;
    localparam int STATUS_BIT   = 12;
    localparam int MASK_BIT     = 16;
    localparam int PERIODIC_BIT = 17;
    localparam int ENABLE_BIT   = 8;
    localparam int SPUR_KEEP_W  = 10;
    localparam int MAX_SHIFT    = 7;
    localparam int PRESC_W      = MAX_SHIFT;
    localparam logic [31:0] ENTRY_KEEP =
        (32'd1 << PERIODIC_BIT) | (32'd1 << STATUS_BIT) | 32'h0000_00FF;

    // 3-bit divide code from the non-contiguous configuration bits
    function automatic logic [2:0] div_code(input logic [3:0] cfg);
        return {cfg[3], cfg[1], cfg[0]};
    endfunction
endpackage

// File: rtl/lit_divider.sv
module lit_divider
    import lit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_i,
    input  logic [3:0] cfg_data_i,
    input  logic       restart_i,
    input  logic       run_i,
    output logic       tick_o
);
    typedef struct packed {
        logic [3:0]         cfg;
        logic [PRESC_W-1:0] presc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [2:0]         shift;
    logic [PRESC_W-1:0] phase_mask;

    always_comb begin
        st_d       = st_q;
        shift      = div_code(st_q.cfg) + 3'd1;
        phase_mask = PRESC_W'((32'd1 << shift) - 32'd1);
        tick_o     = run_i && ((st_q.presc & phase_mask) == phase_mask);
        if (cfg_wr_i)
            st_d.cfg = cfg_data_i;
        if (restart_i)
            st_d.presc = '0;
        else
            st_d.presc = st_q.presc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R2
    back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(tick_o) && !$past(restart_i) && !$past(cfg_wr_i))
        |-> (div_code(st_q.cfg) == 3'b111));
endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             periodic_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] init;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.cnt  = load_val_i;
            st_d.init = load_val_i;
        end else if (tick_i && (st_q.cnt != '0)) begin
            if (st_q.cnt == CNT_W'(1)) begin
                expire_o = 1'b1;
                st_d.cnt = periodic_i ? st_q.init : '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count_o   = st_q.cnt;
    assign running_o = (st_q.cnt != '0);

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !expire_o)
        |=> (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !periodic_i) |=> (count_o == '0));
    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && periodic_i) |=> (count_o == st_q.init));
    // R10
    zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && !load_i) |=> (count_o == '0));
endmodule

// File: rtl/lit_config.sv
module lit_config
    import lit_pkg::*;
#(
    parameter int ENTRIES = 6,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spur_wr_i,
    input  logic [31:0]        spur_data_i,
    input  logic               ent_wr_i,
    input  logic [SEL_W-1:0]   ent_sel_i,
    input  logic [31:0]        ent_data_i,
    output logic               sw_en_o,
    output logic               disable_evt_o,
    output logic [31:0]        spur_q_o,
    output logic [31:0]        timer_entry_o,
    output logic [ENTRIES-1:0] masked_o
);
    typedef struct packed {
        logic [SPUR_KEEP_W-1:0] spur;
        logic [31:0]            tfields;
        logic [ENTRIES-1:0]     masks;
    } cfg_st_t;

    cfg_st_t     st_d, st_q;
    logic        eff_en;
    logic [31:0] forced;

    always_comb begin
        st_d          = st_q;
        disable_evt_o = spur_wr_i && !spur_data_i[ENABLE_BIT];
        eff_en        = spur_wr_i ? spur_data_i[ENABLE_BIT] : st_q.spur[ENABLE_BIT];
        forced        = ent_data_i | (eff_en ? 32'd0 : (32'd1 << MASK_BIT));
        if (spur_wr_i) begin
            st_d.spur = spur_data_i[SPUR_KEEP_W-1:0];
            if (disable_evt_o)
                st_d.masks = '1;
        end
        if (ent_wr_i) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (int'(ent_sel_i) == e)
                    st_d.masks[e] = forced[MASK_BIT];
            end
            if (ent_sel_i == '0)
                st_d.tfields = forced & ENTRY_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.spur    <= '0;
            st_q.tfields <= '0;
            st_q.masks   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_en_o       = st_q.spur[ENABLE_BIT];
    assign spur_q_o      = 32'(st_q.spur);
    assign masked_o      = st_q.masks;
    assign timer_entry_o = st_q.tfields | (32'(st_q.masks[0]) << MASK_BIT);

    // R7
    disabled_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en_o |-> (&masked_o));
    // R8
    forced_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_wr_i && !spur_wr_i && !sw_en_o && int'(ent_sel_i) < ENTRIES)
        |=> masked_o[$past(ent_sel_i)]);
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
    import lit_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int ENTRIES = 6,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_wr,
    input  logic [CNT_W-1:0]   init_data,
    input  logic               div_wr,
    input  logic [3:0]         div_data,
    input  logic               spur_wr,
    input  logic [31:0]        spur_data,
    input  logic               ent_wr,
    input  logic [SEL_W-1:0]   ent_sel,
    input  logic [31:0]        ent_data,
    output logic [CNT_W-1:0]   cur_count,
    output logic [31:0]        timer_entry,
    output logic [ENTRIES-1:0] entry_masked,
    output logic [31:0]        spur_q,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } irq_st_t;

    irq_st_t irq_d, irq_q;
    logic    sw_en, disable_evt, running, tick, expire;

    lit_config #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .spur_wr_i     (spur_wr),
        .spur_data_i   (spur_data),
        .ent_wr_i      (ent_wr),
        .ent_sel_i     (ent_sel),
        .ent_data_i    (ent_data),
        .sw_en_o       (sw_en),
        .disable_evt_o (disable_evt),
        .spur_q_o      (spur_q),
        .timer_entry_o (timer_entry),
        .masked_o      (entry_masked)
    );

    lit_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (div_wr),
        .cfg_data_i (div_data),
        .restart_i  (init_wr),
        .run_i      (running),
        .tick_o     (tick)
    );

    lit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (init_wr),
        .load_val_i (init_data),
        .tick_i     (tick),
        .periodic_i (timer_entry[PERIODIC_BIT]),
        .count_o    (cur_count),
        .running_o  (running),
        .expire_o   (expire)
    );

    always_comb begin
        irq_d.valid = expire && sw_en && !entry_masked[0] && !disable_evt;
        irq_d.vec   = timer_entry[VEC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= irq_d;
    end

    assign irq_valid  = irq_q.valid;
    assign irq_vector = irq_q.vec;

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(expire && sw_en && !entry_masked[0]));
    // R6
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector == $past(timer_entry[VEC_W-1:0])));
    // R7
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disable_evt |=> !irq_valid);
endmodule

// File: tb/local_irq_timer_bench.sv
module local_irq_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;
    localparam int ENTRIES    = 6;
    localparam int SEL_W      = $clog2(ENTRIES);

    typedef struct packed {
        logic [3:0]  div;
        logic [15:0] n;
        logic        per;
        logic [7:0]  vec;
        logic [15:0] ratio;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC_TAB [NVEC] = '{
        '{4'b1011, 16'd5, 1'b0, 8'h31, 16'd1},
        '{4'b0000, 16'd3, 1'b0, 8'h42, 16'd2},
        '{4'b0100, 16'd3, 1'b1, 8'h53, 16'd2},
        '{4'b0001, 16'd4, 1'b1, 8'h64, 16'd4},
        '{4'b0011, 16'd2, 1'b0, 8'h75, 16'd16},
        '{4'b1000, 16'd2, 1'b1, 8'h86, 16'd32},
        '{4'b1010, 16'd1, 1'b0, 8'h97, 16'd128},
        '{4'b1001, 16'd1, 1'b1, 8'hA8, 16'd64},
        '{4'b1011, 16'd1, 1'b1, 8'hB9, 16'd1}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               init_wr = 1'b0;
    logic [CNT_W-1:0]   init_data = '0;
    logic               div_wr = 1'b0;
    logic [3:0]         div_data = '0;
    logic               spur_wr = 1'b0;
    logic [31:0]        spur_data = '0;
    logic               ent_wr = 1'b0;
    logic [SEL_W-1:0]   ent_sel = '0;
    logic [31:0]        ent_data = '0;
    logic [CNT_W-1:0]   cur_count;
    logic [31:0]        timer_entry;
    logic [ENTRIES-1:0] entry_masked;
    logic [31:0]        spur_q;
    logic               irq_valid;
    logic [7:0]         irq_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    local_irq_timer #(.CNT_W(CNT_W), .ENTRIES(ENTRIES)) u_local_irq_timer (
        .clk(clk), .rst_n(rst_n),
        .init_wr(init_wr), .init_data(init_data),
        .div_wr(div_wr), .div_data(div_data),
        .spur_wr(spur_wr), .spur_data(spur_data),
        .ent_wr(ent_wr), .ent_sel(ent_sel), .ent_data(ent_data),
        .cur_count(cur_count), .timer_entry(timer_entry),
        .entry_masked(entry_masked), .spur_q(spur_q),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_init(input logic [31:0] v);
        init_wr = 1'b1; init_data = v;
        @(negedge clk);
        init_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [3:0] v);
        div_wr = 1'b1; div_data = v;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic wr_spur(input logic [31:0] v);
        spur_wr = 1'b1; spur_data = v;
        @(negedge clk);
        spur_wr = 1'b0;
    endtask

    task automatic wr_ent(input int sel, input logic [31:0] v);
        ent_wr = 1'b1; ent_sel = SEL_W'(sel); ent_data = v;
        @(negedge clk);
        ent_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "count", cur_count, 32'd0);
        chk("R1", "timer entry", timer_entry, 32'h0001_0000);
        chk("R1", "masks", 32'(entry_masked), 32'h3F);
        chk("R1", "enable reg", spur_q, 32'd0);
        chk("R1", "irq", 32'(irq_valid), 32'd0);

        // R9 kept bits
        wr_spur(32'hFFFF_F3FF);
        chk("R9", "enable reg bits", spur_q, 32'h0000_03FF);
        wr_ent(0, 32'hFFFF_FFFF);
        chk("R9", "timer entry bits", timer_entry, 32'h0003_10FF);

        // table walk: R2 ratio/decrement, R4 one-shot, R5 periodic, R6 vector
        for (int i = 0; i < NVEC; i++) begin
            automatic vec_t v = VEC_TAB[i];
            automatic int n = int'(v.n);
            automatic int r = int'(v.ratio);
            automatic int cyc = n * r;
            automatic int len = v.per ? 2 * cyc + 1 : cyc + 3;
            automatic logic [31:0] c_act = 0, c_exp = 0, i_act = 0, i_exp = 0;
            automatic logic [31:0] v_act = 0;
            automatic bit c_bad = 0, i_bad = 0, v_bad = 0;
            wr_ent(0, 32'(v.vec) | (32'(v.per) << 17));
            wr_div(v.div);
            wr_init(32'(n));
            for (int k = 1; k <= len; k++) begin
                automatic int expc;
                automatic bit expi;
                @(negedge clk);
                if (v.per) begin
                    expc = n - (k % cyc) / r;
                    expi = ((k % cyc) == 0);
                end else begin
                    expc = (k >= cyc) ? 0 : n - k / r;
                    expi = (k == cyc);
                end
                if (!c_bad && cur_count !== 32'(expc)) begin
                    c_bad = 1; c_act = cur_count; c_exp = 32'(expc);
                end
                if (!i_bad && irq_valid !== expi) begin
                    i_bad = 1; i_act = 32'(irq_valid); i_exp = 32'(expi);
                end
                if (!v_bad && irq_valid && irq_vector !== v.vec) begin
                    v_bad = 1; v_act = 32'(irq_vector);
                end
            end
            chk("R2", $sformatf("count trace vec%0d", i), c_act, c_exp);
            chk(v.per ? "R5" : "R4", $sformatf("irq timing vec%0d", i), i_act, i_exp);
            chk("R6", $sformatf("irq vector vec%0d", i), v_bad ? v_act : 32'(v.vec), 32'(v.vec));
            wr_init(32'd0);
        end

        // R3 restart while running
        wr_ent(0, 32'h0000_0011);
        wr_div(4'b1011);
        wr_init(32'd10);
        repeat (4) @(negedge clk);
        chk("R2", "count mid run", cur_count, 32'd6);
        wr_init(32'd3);
        chk("R3", "count after reload", cur_count, 32'd3);
        @(negedge clk);
        @(negedge clk);
        chk("R3", "no early irq", 32'(irq_valid), 32'd0);
        @(negedge clk);
        chk("R3", "irq at new expiry", 32'(irq_valid), 32'd1);
        chk("R4", "count held at zero", cur_count, 32'd0);
        @(negedge clk);
        chk("R4", "single pulse", 32'(irq_valid), 32'd0);

        // R10 zero initial count
        begin
            automatic int seen = 0;
            wr_init(32'd0);
            chk("R10", "count zero", cur_count, 32'd0);
            repeat (40) begin
                @(negedge clk);
                if (irq_valid || cur_count != 0) seen++;
            end
            chk("R10", "idle cycles", 32'(seen), 32'd0);
        end

        // R6 masked expiry still counts
        begin
            automatic int seen = 0;
            wr_ent(0, 32'h0001_0022);
            wr_init(32'd2);
            repeat (4) begin
                @(negedge clk);
                if (irq_valid) seen++;
            end
            chk("R6", "masked irqs", 32'(seen), 32'd0);
            chk("R6", "masked count", cur_count, 32'd0);
        end

        // R8 enabled entry write stores mask as written
        wr_ent(3, 32'h0000_0000);
        chk("R8", "entry3 unmasked", 32'(entry_masked[3]), 32'd0);

        // R7 disable on the expiry edge drops the request and masks all
        wr_ent(0, 32'h0000_0055);
        wr_div(4'b1011);
        wr_init(32'd2);
        @(negedge clk);
        spur_wr = 1'b1; spur_data = 32'h0000_00FF;
        @(negedge clk);
        spur_wr = 1'b0;
        chk("R7", "dropped irq", 32'(irq_valid), 32'd0);
        chk("R7", "all masked", 32'(entry_masked), 32'h3F);
        chk("R7", "timer mask bit", timer_entry, 32'h0001_0055);

        // R8 writes while disabled forced masked
        wr_ent(3, 32'h0000_0000);
        chk("R8", "entry3 forced", 32'(entry_masked[3]), 32'd1);
        wr_ent(0, 32'h0000_0040);
        chk("R8", "timer forced", timer_entry, 32'h0001_0040);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule